// File: doc/BRIEF.md
# Accelerator Kill Sequencer

This block is the central state machine that takes an accelerator from an alarm to a safe state. Five alarm sources feed it: a watchdog expiry, a tamper or glitch sensor, a DMA range violation, an operator command from the out-of-band controller and a policy command from the orchestrator. Any of them starts a fixed walk through seven steps. Containment comes first: DMA fence, scheduler halt with kernel preemption, link gate, clock cap. Sanitization follows: key zeroize, memory scrub, log seal. Each step is a request/acknowledge handshake with the unit that does the work. The block then strobes kill completion to the board controller and parks in the exit state chosen when the kill began.

A kill targets one partition, all partitions or the whole device. Alarms that arrive while a kill is running are merged into the recorded cause and can only widen the scope. A separate degrade request issues the clock cap alone and then returns to idle. Every step has a bounded wait. A unit that never acknowledges turns the kill into a device-wide reset request, so the total time is bounded whatever software does.

Top module: `kill_seq`

## Requirements
- R1: After reset all step requests are low. `kill_done`, `dev_reset_req`, `maint_mode` and `degraded` are low, `stat_state` is 0 (idle) and `stat_cause` is 0.
- R2: A high bit on `trig` while idle moves `stat_state` to 1 (armed) at the next clock edge and loads the bits into `stat_cause`. The bits are: 0 watchdog, 1 tamper, 2 DMA violation, 3 operator, 4 orchestrator.
- R3: `sw_cancel` while armed returns the block to idle with the cause cleared, and no step is requested. From the first step onward (`stat_state` 2) `sw_cancel` has no effect.
- R4: Steps are requested one at a time, on `step_req` bit 0 DMA fence, 1 scheduler halt, 2 link gate, 3 clock cap, 4 key zeroize, 5 scrub, 6 log seal, in that order. Each request is held until its own acknowledge. Bits 0 to 3 are all acknowledged before bit 4 is raised. `stat_state` is 2 and `stat_step` gives the bit index.
- R5: One clock after the log-seal acknowledge is taken, `kill_done` is high for exactly one cycle.
- R6: `exit_maint` is sampled with the starting alarm. If it was 1, `maint_mode` rises after `kill_done` and stays high (`stat_state` 5). If it was 0, `dev_reset_req` does so instead (`stat_state` 4). The two are never high together.
- R7: A step whose acknowledge does not come is requested for exactly `STEP_TMO` cycles (`SCRUB_TMO` for the scrub step). The block then drops all requests, raises `dev_reset_req`, enters `stat_state` 6 and never raises `kill_done`.
- R8: `trig_scope` is 0 for one partition, 1 for all partitions and 2 for the device; 3 counts as device. The scope is latched with the alarm, and a tamper alarm always gives device scope. `cmd_scope` and `cmd_part` (the partition from `trig_part`) are valid with every request.
- R9: Alarms during a running kill are ORed into `stat_cause`. `cmd_scope` takes the wider of the running scope and the new one and never narrows.
- R10: `degrade_req` while idle with no alarm enters `stat_state` 7 and requests only `step_req` bit 3. On its acknowledge the block returns to idle with `degraded` set and held, and no `kill_done`. A missing acknowledge escalates as in R7.
- R11: `stat_scrub` counts `scrub_beat` pulses seen while the scrub step is requested, saturating. It is cleared when a kill starts, and beats at any other time are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 5 | Alarm sources (bit map in R2) |
| trig_scope | input | 2 | Requested scope for an alarm or degrade |
| trig_part | input | PW | Target partition |
| exit_maint | input | 1 | 1: end in maintenance, 0: end in reset |
| sw_cancel | input | 1 | Software cancel, honoured only while armed |
| degrade_req | input | 1 | Clock-cap-only request |
| step_req | output | 7 | One-hot step requests |
| step_ack | input | 7 | Step acknowledges |
| scrub_beat | input | 1 | Scrub progress pulse |
| cmd_scope | output | 2 | Scope sent with each request |
| cmd_part | output | PW | Partition sent with each request |
| kill_done | output | 1 | Kill-complete strobe to the board controller |
| dev_reset_req | output | 1 | Device reset request (exit or escalation) |
| maint_mode | output | 1 | Maintenance exit state |
| degraded | output | 1 | Clock cap held by a degrade |
| stat_cause | output | 5 | Merged alarm cause |
| stat_state | output | 3 | 0 idle, 1 armed, 2 step, 3 done, 4 reset, 5 maintenance, 6 escalated, 7 degrade |
| stat_step | output | 3 | Current step index |
| stat_scrub | output | SCNT_W | Scrub progress count |

## Verification
Some properties are checked on every cycle: at most one request at a time, no sanitizing request before the clock cap has been acknowledged, completion only after a seal handshake, sticky and exclusive exit states, no return to idle once steps began, scope that never narrows during steps, and a bound on how long any request stays up. The bench scenarios show what depends on particular input sequences. These are the exact step order, cancel accepted while armed but ignored later, the exact timeout lengths for an ordinary step and for the scrub step, cause merging with scope widening, the degrade path, and counting of scrub beats only inside the scrub step.

// File: rtl/kill_seq.sv
module kill_seq #(
  parameter int PW        = 3,
  parameter int STEP_TMO  = 8,
  parameter int SCRUB_TMO = 32,
  parameter int SCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        trig,
  input  logic [1:0]        trig_scope,
  input  logic [PW-1:0]     trig_part,
  input  logic              exit_maint,
  input  logic              sw_cancel,
  input  logic              degrade_req,
  output logic [6:0]        step_req,
  input  logic [6:0]        step_ack,
  input  logic              scrub_beat,
  output logic [1:0]        cmd_scope,
  output logic [PW-1:0]     cmd_part,
  output logic              kill_done,
  output logic              dev_reset_req,
  output logic              maint_mode,
  output logic              degraded,
  output logic [4:0]        stat_cause,
  output logic [2:0]        stat_state,
  output logic [2:0]        stat_step,
  output logic [SCNT_W-1:0] stat_scrub
);
  localparam int TW = $clog2(SCRUB_TMO + 1);
  localparam logic [TW-1:0] LIM_N = TW'(STEP_TMO - 1);
  localparam logic [TW-1:0] LIM_S = TW'(SCRUB_TMO - 1);
  localparam logic [2:0] SCRUB_IX = 3'd5;
  localparam logic [2:0] LAST_IX  = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ARM = 3'd1, S_STEP = 3'd2, S_DONE = 3'd3,
    S_RSTX = 3'd4, S_MAINT = 3'd5, S_ESC = 3'd6, S_DEGR = 3'd7
  } st_t;

  st_t               st;
  logic [2:0]        k;
  logic [TW-1:0]     tmr;
  logic [4:0]        cause;
  logic [1:0]        scope;
  logic [PW-1:0]     part;
  logic              exit_q, deg_q;
  logic [SCNT_W-1:0] scnt;

  wire         any_trig = |trig;
  wire [1:0]   ns       = (trig[1] || trig_scope == 2'd3) ? 2'd2 : trig_scope;
  wire         cur_ack  = step_ack[k];
  wire [TW-1:0] lim     = (k == SCRUB_IX) ? LIM_S : LIM_N;

  assign step_req      = (st == S_STEP) ? (7'd1 << k) : (st == S_DEGR) ? 7'b0001000 : 7'd0;
  assign cmd_scope     = scope;
  assign cmd_part      = part;
  assign kill_done     = (st == S_DONE);
  assign dev_reset_req = (st == S_RSTX) || (st == S_ESC);
  assign maint_mode    = (st == S_MAINT);
  assign degraded      = deg_q;
  assign stat_cause    = cause;
  assign stat_state    = st;
  assign stat_step     = k;
  assign stat_scrub    = scnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; tmr <= '0; cause <= '0; scope <= '0;
      part <= '0; exit_q <= 1'b0; deg_q <= 1'b0; scnt <= '0;
    end else begin
      cause <= cause | trig;
      if (any_trig && ns > scope) scope <= ns;
      case (st)
        S_IDLE: begin
          tmr <= '0;
          k   <= '0;
          if (any_trig) begin
            st <= S_ARM; cause <= trig; scope <= ns; part <= trig_part;
            exit_q <= exit_maint; scnt <= '0;
          end else if (degrade_req) begin
            st <= S_DEGR; scope <= ns; part <= trig_part;
          end
        end
        S_ARM: begin
          if (sw_cancel) begin
            st <= S_IDLE; cause <= '0; scope <= '0;
          end else begin
            st <= S_STEP;
          end
        end
        S_STEP: begin
          if (k == SCRUB_IX && scrub_beat && scnt != {SCNT_W{1'b1}})
            scnt <= scnt + 1'b1;
          if (cur_ack) begin
            tmr <= '0;
            if (k == LAST_IX) st <= S_DONE;
            else k <= k + 1'b1;
          end else if (tmr == lim) begin
            st <= S_ESC;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_DEGR: begin
          if (any_trig && cause == '0) begin
            exit_q <= exit_maint; scnt <= '0;
          end
          if (step_ack[3]) begin
            deg_q <= 1'b1;
            tmr   <= '0;
            st    <= (|cause || any_trig) ? S_ARM : S_IDLE;
          end else if (tmr == LIM_N) begin
            st <= S_ESC;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_DONE:  st <= exit_q ? S_MAINT : S_RSTX;
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/kill_seq_chk.sv
module kill_seq_chk #(
  parameter int SCRUB_TMO = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] step_req,
  input logic [6:0] step_ack,
  input logic       kill_done,
  input logic       dev_reset_req,
  input logic       maint_mode,
  input logic [2:0] stat_state,
  input logic [1:0] stat_scope
);
  logic contained;
  int   hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      contained <= 1'b0;
      hold      <= 0;
    end else begin
      if (stat_state == 3'd0) contained <= 1'b0;
      else if (stat_state == 3'd2 && step_req[3] && step_ack[3]) contained <= 1'b1;
      if (step_req != 7'd0 && step_req == $past(step_req)) hold <= hold + 1;
      else hold <= 0;
    end
  end

  p_onehot_req_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(step_req));
  p_contain_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|step_req[6:4]) |-> contained);
  p_done_after_seal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kill_done |-> $past(step_req[6] && step_ack[6]));
  p_reset_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_req |=> dev_reset_req);
  p_maint_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    maint_mode |=> maint_mode);
  p_exit_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_reset_req && maint_mode));
  p_no_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 3'd2) |=> (stat_state != 3'd0));
  p_scope_widen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == 3'd2) |=> (stat_state != 3'd2 || stat_scope >= $past(stat_scope)));
  p_bounded_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold < SCRUB_TMO);
endmodule

bind kill_seq kill_seq_chk #(.SCRUB_TMO(SCRUB_TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_ack(step_ack),
  .kill_done(kill_done), .dev_reset_req(dev_reset_req), .maint_mode(maint_mode),
  .stat_state(stat_state), .stat_scope(cmd_scope)
);

// File: tb/tb_kill_seq.sv
module tb_kill_seq;
  localparam int PW = 3, STEP_TMO = 8, SCRUB_TMO = 32, SCNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] trig = '0;
  logic [1:0] trig_scope = '0;
  logic [PW-1:0] trig_part = '0;
  logic exit_maint = 1'b0, sw_cancel = 1'b0, degrade_req = 1'b0, scrub_beat = 1'b0;
  logic [6:0] step_ack = '0;
  logic [6:0] step_req;
  logic [1:0] cmd_scope;
  logic [PW-1:0] cmd_part;
  logic kill_done, dev_reset_req, maint_mode, degraded;
  logic [4:0] stat_cause;
  logic [2:0] stat_state, stat_step;
  logic [SCNT_W-1:0] stat_scrub;

  kill_seq #(.PW(PW), .STEP_TMO(STEP_TMO), .SCRUB_TMO(SCRUB_TMO), .SCNT_W(SCNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_scope(trig_scope), .trig_part(trig_part),
    .exit_maint(exit_maint), .sw_cancel(sw_cancel), .degrade_req(degrade_req),
    .step_req(step_req), .step_ack(step_ack), .scrub_beat(scrub_beat),
    .cmd_scope(cmd_scope), .cmd_part(cmd_part), .kill_done(kill_done),
    .dev_reset_req(dev_reset_req), .maint_mode(maint_mode), .degraded(degraded),
    .stat_cause(stat_cause), .stat_state(stat_state), .stat_step(stat_step),
    .stat_scrub(stat_scrub));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int dly[7];
  bit stall[7];
  int acnt[7];
  int ord[16];
  int ord_n, kd_cnt;
  int run[7], cur[7];
  logic [6:0] prev_req;

  always @(negedge clk) begin
    if (!rst_n) begin
      step_ack = '0;
      for (int i = 0; i < 7; i++) acnt[i] = 0;
    end else begin
      for (int i = 0; i < 7; i++) begin
        if (step_req[i] && !stall[i]) begin
          if (acnt[i] >= dly[i]) step_ack[i] = 1'b1;
          else acnt[i]++;
        end else begin
          step_ack[i] = 1'b0;
          acnt[i] = 0;
        end
        if (step_req[i]) begin
          cur[i]++;
          if (cur[i] > run[i]) run[i] = cur[i];
        end else cur[i] = 0;
      end
      if (step_req != prev_req && step_req != 7'd0 && ord_n < 16)
        for (int i = 0; i < 7; i++) if (step_req[i]) begin ord[ord_n] = i; ord_n++; end
      if (kill_done) kd_cnt++;
      prev_req = step_req;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; trig = '0; trig_scope = '0; trig_part = '0; exit_maint = 1'b0;
    sw_cancel = 1'b0; degrade_req = 1'b0; scrub_beat = 1'b0;
    for (int i = 0; i < 7; i++) begin dly[i] = 1; stall[i] = 0; run[i] = 0; cur[i] = 0; end
    ord_n = 0; kd_cnt = 0; prev_req = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_trig(input logic [4:0] b, input logic [1:0] sc, input logic [PW-1:0] p, input logic em);
    trig = b; trig_scope = sc; trig_part = p; exit_maint = em;
    tick();
    trig = '0; trig_scope = '0; exit_maint = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400; i++) begin
      if (stat_state == 3'd4 || stat_state == 3'd5 || stat_state == 3'd6) break;
      tick();
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(step_req == 0 && !kill_done && !dev_reset_req && !maint_mode && !degraded, "R1 outputs", int'(step_req), 0);
    chk(stat_state == 0 && stat_cause == 0, "R1 status", int'(stat_state), 0);
  endtask

  task automatic t_full_reset_exit();
    do_reset();
    pulse_trig(5'b01000, 2'd1, 3'd3, 1'b0);
    chk(stat_state == 3'd1, "R2 armed", int'(stat_state), 1);
    chk(stat_cause == 5'b01000, "R2 cause", int'(stat_cause), 8);
    tick();
    chk(stat_state == 3'd2 && step_req == 7'd1 && stat_step == 0, "R4 first step", int'(step_req), 1);
    chk(cmd_scope == 2'd1 && cmd_part == 3'd3, "R8 scope/part", int'(cmd_scope), 1);
    sw_cancel = 1'b1; tick(); sw_cancel = 1'b0;
    chk(stat_state == 3'd2, "R3 cancel ignored", int'(stat_state), 2);
    wait_end();
    chk(ord_n == 7, "R4 step count", ord_n, 7);
    for (int i = 0; i < 7; i++) chk(ord[i] == i, "R4 order", ord[i], i);
    chk(kd_cnt == 1, "R5 one strobe", kd_cnt, 1);
    chk(dev_reset_req && !maint_mode && stat_state == 3'd4, "R6 reset exit", int'(stat_state), 4);
  endtask

  task automatic t_cancel();
    do_reset();
    pulse_trig(5'b00001, 2'd0, 3'd0, 1'b0);
    sw_cancel = 1'b1; tick(); sw_cancel = 1'b0;
    chk(stat_state == 3'd0 && stat_cause == 0, "R3 cancel armed", int'(stat_state), 0);
    tick(); tick();
    chk(ord_n == 0 && step_req == 0, "R3 no steps", ord_n, 0);
  endtask

  task automatic t_maint_tamper();
    do_reset();
    pulse_trig(5'b00010, 2'd0, 3'd5, 1'b1);
    tick();
    chk(cmd_scope == 2'd2, "R8 tamper device scope", int'(cmd_scope), 2);
    wait_end();
    chk(maint_mode && !dev_reset_req && stat_state == 3'd5, "R6 maint exit", int'(stat_state), 5);
    chk(kd_cnt == 1 && stat_cause == 5'b00010, "R5 strobe and cause", kd_cnt, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    stall[2] = 1;
    pulse_trig(5'b00100, 2'd0, 3'd1, 1'b1);
    wait_end();
    chk(stat_state == 3'd6 && dev_reset_req && !maint_mode, "R7 escalate", int'(stat_state), 6);
    chk(run[2] == STEP_TMO, "R7 step window", run[2], STEP_TMO);
    chk(kd_cnt == 0 && step_req == 0 && ord_n == 3, "R7 no done", kd_cnt, 0);
    do_reset();
    stall[5] = 1;
    pulse_trig(5'b10000, 2'd1, 3'd1, 1'b0);
    wait_end();
    chk(run[5] == SCRUB_TMO, "R7 scrub window", run[5], SCRUB_TMO);
    chk(stat_state == 3'd6 && kd_cnt == 0, "R7 scrub escalate", int'(stat_state), 6);
  endtask

  task automatic t_merge();
    do_reset();
    dly[1] = 5;
    pulse_trig(5'b00100, 2'd0, 3'd1, 1'b0);
    for (int i = 0; i < 20 && !step_req[1]; i++) tick();
    chk(cmd_scope == 2'd0, "R9 scope before", int'(cmd_scope), 0);
    pulse_trig(5'b00001, 2'd2, 3'd6, 1'b1);
    chk(stat_cause == 5'b00101, "R9 cause merge", int'(stat_cause), 5);
    chk(cmd_scope == 2'd2 && cmd_part == 3'd1, "R9 scope widened", int'(cmd_scope), 2);
    pulse_trig(5'b01000, 2'd0, 3'd0, 1'b0);
    chk(cmd_scope == 2'd2, "R9 never narrows", int'(cmd_scope), 2);
    wait_end();
    chk(kd_cnt == 1 && dev_reset_req, "R6 exit kept from start", kd_cnt, 1);
  endtask

  task automatic t_degrade();
    do_reset();
    dly[3] = 2;
    degrade_req = 1'b1; trig_scope = 2'd1; trig_part = 3'd2; tick();
    degrade_req = 1'b0; trig_scope = 2'd0;
    chk(stat_state == 3'd7 && step_req == 7'b0001000, "R10 cap only", int'(step_req), 8);
    chk(cmd_scope == 2'd1 && cmd_part == 3'd2, "R10 scope", int'(cmd_scope), 1);
    for (int i = 0; i < 20 && stat_state != 3'd0; i++) tick();
    chk(stat_state == 3'd0 && degraded, "R10 back idle degraded", int'(stat_state), 0);
    chk(ord_n == 1 && kd_cnt == 0 && !dev_reset_req, "R10 no kill", ord_n, 1);
    do_reset();
    stall[3] = 1;
    degrade_req = 1'b1; tick(); degrade_req = 1'b0;
    for (int i = 0; i < 40 && stat_state != 3'd6; i++) tick();
    chk(stat_state == 3'd6 && dev_reset_req && run[3] == STEP_TMO, "R10 timeout escalates", run[3], STEP_TMO);
  endtask

  task automatic t_scrub();
    do_reset();
    dly[5] = 10;
    pulse_trig(5'b00001, 2'd2, 3'd0, 1'b0);
    scrub_beat = 1'b1; tick(); scrub_beat = 1'b0;
    for (int i = 0; i < 40 && !step_req[5]; i++) tick();
    chk(stat_scrub == 0, "R11 beat outside scrub", int'(stat_scrub), 0);
    for (int j = 0; j < 3; j++) begin scrub_beat = 1'b1; tick(); scrub_beat = 1'b0; tick(); end
    wait_end();
    chk(stat_scrub == 3, "R11 beats counted", int'(stat_scrub), 3);
    chk(kd_cnt == 1, "R5 done after scrub", kd_cnt, 1);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_reset_exit();
    t_cancel();
    t_maint_tamper();
    t_timeout();
    t_merge();
    t_degrade();
    t_scrub();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule